// File: doc/BRIEF.md
# Ring Collapse-Cycle Counter with LSB Harvester

This block sits next to a tunable even-stage ring oscillator. Two edges are launched into that ring, and they race each other until one catches the other. The block counts the ring cycles that pass before the oscillation dies. When the ring stops toggling, the count stops growing without any extra detector. The count is then latched at the next rising edge of a slow control clock and presented to the tuning controller together with a one-cycle valid pulse.

The control clock sets two phases. While it is high, the block is in its clearing phase: the counter is held at zero and the launch output is low. When it falls, evaluation begins: the launch output rises, which releases the edges into the ring, and ring cycles are counted. The next rising edge ends evaluation and captures the count. Both the ring output and the control clock are brought into the system clock domain through multi-flop synchronisers. The ring therefore has to toggle more slowly than half the system clock.

From each captured count that is not saturated, a chosen number of low-order bits is shifted out as a random bit stream, one bit per system clock, each with its own valid strobe. The tuning controller can switch harvesting off with an enable input, for example while it is still searching for a good ring configuration.

Top module: `collapse_harvest`

## Requirements
- R1: After reset, count_o is 0, and count_vld_o, ovf_o, rbit_vld_o and inject_o are all 0.
- R2: inject_o is low while ctl_clk_i is high (clearing phase). It goes high within a few system cycles after ctl_clk_i falls (evaluation), and it is low again when the captured count is presented.
- R3: The captured count equals the number of rising edges of ring_i seen during evaluation. Every evaluation starts again from zero.
- R4: A rising edge of ctl_clk_i that ends an evaluation produces exactly one single-cycle count_vld_o pulse. count_o changes only in that cycle and holds its value until the next capture.
- R5: The counter saturates at 2^CNT_W-1 (511 by default). ovf_o is 1 with a capture exactly when the count reached that value, and 0 otherwise.
- R6: For a harvested sample, the requested number of low-order count bits appears on rbit_o, least significant bit first, one per cycle with rbit_vld_o high. The first bit appears in the cycle after count_vld_o.
- R7: A harvest width request of 0 on nbits_i selects DEF_BITS (3 by default). A request larger than CNT_W is clamped to CNT_W.
- R8: A capture with ovf_o = 1 produces no harvested bits.
- R9: A capture made while bits_en_i is low produces no harvested bits, but count_o and count_vld_o behave as usual.
- R10: If a new sample is captured while bits of the previous one are still being shifted out, the rest of the previous sample is dropped. The new sample's bits follow in the very next cycle.
- R11: Ring edges that arrive during the clearing phase affect neither count_o nor the next captured count, and they produce no count_vld_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_i | input | 1 | Ring oscillator output (asynchronous) |
| ctl_clk_i | input | 1 | Control clock: high = clearing phase, low = evaluation, rising edge = capture |
| bits_en_i | input | 1 | Harvest enable from the tuning controller |
| nbits_i | input | $clog2(CNT_W+1) | Number of LSBs to harvest (0 = default) |
| inject_o | output | 1 | Edge-launch strobe, high during evaluation |
| count_o | output | CNT_W | Last captured collapse count |
| count_vld_o | output | 1 | One-cycle pulse with each new count |
| ovf_o | output | 1 | Captured count reached saturation |
| rbit_o | output | 1 | Harvested random bit |
| rbit_vld_o | output | 1 | rbit_o holds a valid bit |

## Verification
A new capture and the shifting out of the previous sample's bits can fall in the same cycle. This is provoked by a wide 9-bit harvest followed by a very short clearing phase and a short second evaluation, so the second count_vld_o arrives while the first stream is still running. It is judged from the port-level timing of the two capture pulses: for a gap of k cycles, the bench expects exactly the first k bits of the first count followed by all nine bits of the second. Saturation at exactly 510, 511 and more edges is also checked, together with the enable and width-clamping paths.

// File: rtl/ch_pkg.sv
package ch_pkg;

   typedef enum logic {PH_CLEAR = 1'b0, PH_EVAL = 1'b1} phase_e;

   // Map a harvest-width request to the number of bits actually shifted.
   function automatic int unsigned eff_bits(input int unsigned req,
                                            input int unsigned dflt,
                                            input int unsigned width);
      if (req == 0)
         return dflt;
      else if (req > width)
         return width;
      else
         return req;
   endfunction

endpackage

// File: rtl/ch_sync.sv
module ch_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ch_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("ch_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain_q <= '0;
      else
         chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ch_cycle_count.sv
module ch_cycle_count #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ring_s,
   input  logic             ctl_s,
   output logic             inject,
   output logic [CNT_W-1:0] count,
   output logic             count_vld,
   output logic             ovf
);
   import ch_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             ring_prev_q, ctl_prev_q;
   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ring_rise, ctl_rise, ctl_fall;

   assign ring_rise = ring_s & ~ring_prev_q;
   assign ctl_rise  = ctl_s & ~ctl_prev_q;
   assign ctl_fall  = ~ctl_s & ctl_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_prev_q <= 1'b0;
         ctl_prev_q  <= 1'b0;
         phase_q     <= PH_CLEAR;
         cnt_q       <= '0;
         count       <= '0;
         count_vld   <= 1'b0;
         ovf         <= 1'b0;
      end else begin
         ring_prev_q <= ring_s;
         ctl_prev_q  <= ctl_s;
         count_vld   <= 1'b0;
         if (ctl_fall) begin
            phase_q <= PH_EVAL;
            cnt_q   <= '0;
         end else if (ctl_rise) begin
            phase_q <= PH_CLEAR;
            cnt_q   <= '0;
            if (phase_q == PH_EVAL) begin
               count     <= cnt_q;
               ovf       <= (cnt_q == CNT_MAX);
               count_vld <= 1'b1;
            end
         end else if (phase_q == PH_EVAL) begin
            if (ring_rise && (cnt_q != CNT_MAX))
               cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign inject = (phase_q == PH_EVAL);
endmodule

// File: rtl/ch_lsb_shift.sv
module ch_lsb_shift #(
   parameter int CNT_W = 9,
   parameter int NB_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] data,
   input  logic [NB_W-1:0]  nbits,
   output logic             rbit,
   output logic             rbit_vld
);
   logic [CNT_W-1:0] sh_q;
   logic [NB_W-1:0]  left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= data;
         left_q <= nbits;
      end else if (left_q != '0) begin
         sh_q   <= sh_q >> 1;
         left_q <= left_q - 1'b1;
      end
   end

   assign rbit     = sh_q[0];
   assign rbit_vld = (left_q != '0);
endmodule

// File: rtl/collapse_harvest.sv
module collapse_harvest #(
   parameter int CNT_W       = 9,
   parameter int SYNC_STAGES = 2,
   parameter int DEF_BITS    = 3,
   localparam int NB_W       = $clog2(CNT_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ring_i,
   input  logic             ctl_clk_i,
   input  logic             bits_en_i,
   input  logic [NB_W-1:0]  nbits_i,
   output logic             inject_o,
   output logic [CNT_W-1:0] count_o,
   output logic             count_vld_o,
   output logic             ovf_o,
   output logic             rbit_o,
   output logic             rbit_vld_o
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("collapse_harvest: CNT_W out of range 2..16");
      end
      if (DEF_BITS < 1 || DEF_BITS > CNT_W) begin : g_bad_def
         $error("collapse_harvest: DEF_BITS must lie in 1..CNT_W");
      end
   endgenerate

   logic [1:0]      sync_in, sync_out;
   logic            ring_s, ctl_s;
   logic            load;
   logic [NB_W-1:0] n_eff;

   assign sync_in = {ctl_clk_i, ring_i};

   ch_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_in),
      .q     (sync_out)
   );

   assign ring_s = sync_out[0];
   assign ctl_s  = sync_out[1];

   ch_cycle_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .ring_s    (ring_s),
      .ctl_s     (ctl_s),
      .inject    (inject_o),
      .count     (count_o),
      .count_vld (count_vld_o),
      .ovf       (ovf_o)
   );

   assign n_eff = NB_W'(ch_pkg::eff_bits(int'(nbits_i), DEF_BITS, CNT_W));
   assign load  = count_vld_o & bits_en_i & ~ovf_o;

   ch_lsb_shift #(.CNT_W(CNT_W), .NB_W(NB_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .data     (count_o),
      .nbits    (n_eff),
      .rbit     (rbit_o),
      .rbit_vld (rbit_vld_o)
   );
endmodule

// File: rtl/ch_checker.sv
module ch_checker #(
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inject_o,
   input logic [CNT_W-1:0] count_o,
   input logic             count_vld_o,
   input logic             ovf_o,
   input logic             bits_en_i,
   input logic             rbit_vld_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [7:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (count_vld_o)
         run_q <= '0;
      else
         run_q <= run_q + 8'(rbit_vld_o);
   end

   assert_launch_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count_vld_o |-> !inject_o);

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count_vld_o |=> !count_vld_o);

   assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !count_vld_o |-> $stable(count_o));

   assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count_vld_o && ovf_o) |-> (count_o == CNT_MAX));

   assert_no_harvest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rbit_vld_o) |-> $past(count_vld_o && !ovf_o && bits_en_i));

   assert_stream_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= 8'(CNT_W));
endmodule

bind collapse_harvest ch_checker #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .inject_o    (inject_o),
   .count_o     (count_o),
   .count_vld_o (count_vld_o),
   .ovf_o       (ovf_o),
   .bits_en_i   (bits_en_i),
   .rbit_vld_o  (rbit_vld_o)
);

// File: tb/tb_collapse_harvest.sv
module tb_collapse_harvest;
   localparam int CNT_W = 9;
   localparam int NB_W  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ring_i = 1'b0;
   logic            ctl_clk_i = 1'b1;
   logic            bits_en_i = 1'b1;
   logic [NB_W-1:0] nbits_i = 4'd3;
   logic            inject_o;
   logic [CNT_W-1:0] count_o;
   logic            count_vld_o, ovf_o, rbit_o, rbit_vld_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // collector state
   int cyc = 0;
   int cv_n = 0;
   int b_n = 0;
   int cv_val [8];
   int cv_ovf [8];
   int cv_cyc [8];
   int bits   [32];

   always #4 clk = ~clk;

   collapse_harvest dut (
      .clk(clk), .rst_n(rst_n), .ring_i(ring_i), .ctl_clk_i(ctl_clk_i),
      .bits_en_i(bits_en_i), .nbits_i(nbits_i), .inject_o(inject_o),
      .count_o(count_o), .count_vld_o(count_vld_o), .ovf_o(ovf_o),
      .rbit_o(rbit_o), .rbit_vld_o(rbit_vld_o)
   );

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (count_vld_o) begin
         if (cv_n < 8) begin
            cv_val[cv_n] = int'(count_o);
            cv_ovf[cv_n] = int'(ovf_o);
            cv_cyc[cv_n] = cyc;
         end
         cv_n = cv_n + 1;
      end
      if (rbit_vld_o) begin
         if (b_n < 32) bits[b_n] = int'(rbit_o);
         b_n = b_n + 1;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_obs();
      cv_n = 0;
      b_n  = 0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ring_i = 1'b1; tick(1);
         ring_i = 1'b0; tick(1);
      end
   endtask

   function automatic int stream_val(input int from, input int n);
      int v = 0;
      for (int i = 0; i < n; i++)
         if (from + i < 32) v = v | (bits[from + i] << i);
      return v;
   endfunction

   task automatic run_sample(input int edges, input int pre_ring);
      clear_obs();
      ctl_clk_i = 1'b1; tick(4);
      pulses(pre_ring);
      tick(2);
      ctl_clk_i = 1'b0; tick(3);
      pulses(edges);
      tick(2);
      ctl_clk_i = 1'b1; tick(18);
   endtask

   task automatic t_reset();
      chk("R1", "count_o after reset", int'(count_o), 0);
      chk("R1", "count_vld_o after reset", int'(count_vld_o), 0);
      chk("R1", "ovf_o after reset", int'(ovf_o), 0);
      chk("R1", "rbit_vld_o after reset", int'(rbit_vld_o), 0);
      chk("R1", "inject_o after reset", int'(inject_o), 0);
   endtask

   task automatic t_phase();
      ctl_clk_i = 1'b1; tick(5);
      chk("R2", "inject_o in clearing phase", int'(inject_o), 0);
      ctl_clk_i = 1'b0; tick(5);
      chk("R2", "inject_o in evaluation", int'(inject_o), 1);
      ctl_clk_i = 1'b1; tick(5);
      chk("R2", "inject_o after capture", int'(inject_o), 0);
      tick(12);
   endtask

   task automatic t_basic();
      bits_en_i = 1'b1; nbits_i = 4'd3;
      run_sample(37, 0);
      chk("R4", "capture pulses", cv_n, 1);
      chk("R3", "count of 37 edges", cv_val[0], 37);
      chk("R5", "ovf for 37", cv_ovf[0], 0);
      chk("R4", "count_o held", int'(count_o), 37);
      chk("R6", "bits harvested (3)", b_n, 3);
      chk("R6", "LSB-first value", stream_val(0, 3), 37 & 7);
   endtask

   task automatic t_timing();
      int first;
      bits_en_i = 1'b1; nbits_i = 4'd5;
      clear_obs();
      ctl_clk_i = 1'b1; tick(4);
      ctl_clk_i = 1'b0; tick(3);
      pulses(100);
      tick(2);
      ctl_clk_i = 1'b1;
      first = -1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         #1;
         if (rbit_vld_o && first < 0) first = cyc;
      end
      tick(4);
      chk("R3", "second count restarts from zero", cv_val[0], 100);
      chk("R6", "first bit one cycle after count_vld", first - cv_cyc[0], 1);
      chk("R6", "bits harvested (5)", b_n, 5);
      chk("R6", "value of 5 LSBs", stream_val(0, 5), 100 & 31);
   endtask

   task automatic t_width();
      bits_en_i = 1'b1;
      nbits_i = 4'd0;
      run_sample(45, 0);
      chk("R7", "width 0 selects default 3", b_n, 3);
      chk("R7", "default-width value", stream_val(0, 3), 45 & 7);
      nbits_i = 4'd12;
      run_sample(333, 0);
      chk("R7", "width 12 clamped to 9", b_n, 9);
      chk("R7", "clamped value", stream_val(0, 9), 333);
   endtask

   task automatic t_overflow();
      bits_en_i = 1'b1; nbits_i = 4'd3;
      run_sample(510, 0);
      chk("R5", "510 edges count", cv_val[0], 510);
      chk("R5", "510 edges no ovf", cv_ovf[0], 0);
      chk("R8", "510 edges harvested", b_n, 3);
      run_sample(511, 0);
      chk("R5", "511 edges count", cv_val[0], 511);
      chk("R5", "511 edges ovf", cv_ovf[0], 1);
      chk("R8", "511 edges not harvested", b_n, 0);
      run_sample(530, 0);
      chk("R5", "530 edges saturate", cv_val[0], 511);
      chk("R5", "530 edges ovf", cv_ovf[0], 1);
      chk("R8", "530 edges not harvested", b_n, 0);
   endtask

   task automatic t_bits_off();
      bits_en_i = 1'b0; nbits_i = 4'd4;
      run_sample(21, 0);
      chk("R9", "capture still made", cv_n, 1);
      chk("R9", "count still correct", cv_val[0], 21);
      chk("R9", "no bits while disabled", b_n, 0);
      bits_en_i = 1'b1;
   endtask

   task automatic t_clear_ring();
      nbits_i = 4'd3;
      run_sample(12, 0);
      clear_obs();
      ctl_clk_i = 1'b1;
      pulses(6);
      tick(6);
      chk("R11", "count_o unchanged by clearing-phase edges", int'(count_o), 12);
      chk("R11", "no capture from clearing-phase edges", cv_n, 0);
      chk("R11", "no bits from clearing-phase edges", b_n, 0);
      run_sample(4, 5);
      chk("R11", "edges before evaluation not counted", cv_val[0], 4);
   endtask

   task automatic t_collision();
      int k;
      bits_en_i = 1'b1; nbits_i = 4'd9;
      clear_obs();
      ctl_clk_i = 1'b1; tick(4);
      ctl_clk_i = 1'b0; tick(3);
      pulses(437);
      tick(2);
      ctl_clk_i = 1'b1; tick(2);
      ctl_clk_i = 1'b0; tick(1);
      pulses(2);
      tick(1);
      ctl_clk_i = 1'b1; tick(24);
      chk("R10", "two captures", cv_n, 2);
      chk("R10", "first count", cv_val[0], 437);
      chk("R10", "second count", cv_val[1], 2);
      k = cv_cyc[1] - cv_cyc[0];
      chk("R10", "second capture inside first stream", int'(k < 9), 1);
      chk("R10", "stream length", b_n, k + 9);
      chk("R10", "truncated first sample", stream_val(0, k), 437 & ((1 << k) - 1));
      chk("R10", "full second sample", stream_val(k, 9), 2);
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(3);
      t_reset();
      t_phase();
      t_basic();
      t_timing();
      t_width();
      t_overflow();
      t_bits_off();
      t_clear_ring();
      t_collision();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule